// File: doc/BRIEF.md
# Interlocked Read Handshake Link

This block pairs a read requester with a memory-side responder. The two talk over one set of shared lines that carry first an address and then a data word, plus three control wires: a request strobe, a data-valid strobe, and one acknowledge wire that both sides use. The two sides share no timing agreement. Each side passes the other side's control wires through a two-flop synchronizer, and each step of the exchange waits for an edge from the other party rather than for a fixed number of cycles.

A local client pulses `start_i` with an address. The requester drives the address and raises the request. The responder captures the address and acknowledges. The requester then withdraws the request and releases the lines, and the responder withdraws its acknowledge. The responder fetches the word from its small internal store, drives it, and raises data-valid. The requester captures the word and acknowledges. The responder withdraws data-valid and releases the lines, and finally the requester withdraws its acknowledge. The requester then reports `done_o` with the word on `data_o`.

The shared lines are modelled without tri-states. Each side has its own drive enable, and the line value is the OR of the enabled drivers. The line value and both enables are visible at the top-level ports for observation.

Top module: `rdhs_link`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy_o`, `done_o`, all three control wires and both drive enables read 0.
- R2: A read of address a returns word(a) = ((a × 0x2F1D) mod 2^16) XOR 0x5A3C on `data_o`. `done_o` is high for exactly one cycle, and `data_o` holds the word from that cycle on.
- R3: In the cycle the request strobe rises, the shared lines carry the address in bits [3:0] with zeros above, and the requester's drive enable is high.
- R4: In the cycle data-valid rises, the shared lines carry word(a), and only the responder's drive enable is high.
- R5: The request strobe falls only while the acknowledge wire is high.
- R6: The two drive enables are never high in the same cycle.
- R7: Data-valid falls only while the acknowledge wire is high.
- R8: A `start_i` pulse while `busy_o` is high is ignored: it starts no new request and does not change the result. `busy_o` stays high until the acknowledge wire is low again.
- R9: The acknowledge wire rises no earlier than three cycles after the strobe it answers rose, which is the cost of the synchronizer.
- R10: While neither side drives, the shared lines read all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a read (ignored while busy) |
| addr_i | input | 4 | Address for the read |
| busy_o | output | 1 | Requester is in a transaction |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | 16 | Word returned by the last read |
| rq_line_o | output | 1 | Request strobe wire |
| rdy_line_o | output | 1 | Data-valid strobe wire |
| ack_line_o | output | 1 | Shared acknowledge wire |
| bus_o | output | 16 | Value on the shared address/data lines |
| req_drive_o | output | 1 | Requester drive enable |
| rsp_drive_o | output | 1 | Responder drive enable |

## Verification
The assertions assume that the client only uses `start_i` and `addr_i` as a request pulse with an address sampled in that cycle, and that `addr_i` needs to be valid only while `start_i` is high. The bench therefore changes these inputs only at falling edges. It gives each read a fresh address and treats a pulse made during `busy_o` as a test of rejection, not as a queued request. Because the acknowledge wire is the OR of both sides, the assertions also rely on each side waiting for that wire to read low before it takes its next step. The bench exercises this with back-to-back reads that start in the first idle cycle.

// File: rtl/rdhs_pkg.sv
package rdhs_pkg;

  typedef enum logic [2:0] {
    RQ_IDLE,
    RQ_REQ,
    RQ_WAIT_DATA,
    RQ_ACK_DATA,
    RQ_RELEASE
  } rq_state_t;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_ACK_REQ,
    RS_WAIT_CLR,
    RS_SEND,
    RS_FINISH
  } rs_state_t;

endpackage

// File: rtl/rdhs_sync.sv
module rdhs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rdhs_store.sv
module rdhs_store #(
  parameter int          ADDR_W = 4,
  parameter int          DATA_W = 16,
  parameter logic [31:0] MULT   = 32'h0000_2F1D,
  parameter logic [31:0] SALT   = 32'h0000_5A3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [DATA_W-1:0] word_of(input int unsigned a);
    logic [31:0] prod;
    prod = 32'(a) * MULT;
    return DATA_W'(prod) ^ DATA_W'(SALT);
  endfunction

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  // contents are loaded at reset; there is no write path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= word_of(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= mem_q[raddr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/rdhs_requester.sv
module rdhs_requester
  import rdhs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  input  logic [DATA_W-1:0] bus_i,
  input  logic              rdy_i,
  input  logic              ack_i,
  output logic              rq_o,
  output logic              ack_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] dout_o
);
  localparam int PAD = DATA_W - ADDR_W;

  rq_state_t         st_q;
  logic              rq_q, ack_q, oe_q, done_q;
  logic [DATA_W-1:0] dout_q, data_q;
  logic              rdy_s, ack_s;

  rdhs_sync #(.W(2), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({rdy_i, ack_i}),
    .q_o  ({rdy_s, ack_s})
  );

  // named events for assertions
  logic ev_accept, ev_req_acked, ev_data_seen, ev_rdy_gone, ev_ack_clear;
  assign ev_accept    = (st_q == RQ_IDLE)      && start_i;
  assign ev_req_acked = (st_q == RQ_REQ)       && ack_s;
  assign ev_data_seen = (st_q == RQ_WAIT_DATA) && rdy_s;
  assign ev_rdy_gone  = (st_q == RQ_ACK_DATA)  && !rdy_s;
  assign ev_ack_clear = (st_q == RQ_RELEASE)   && !ack_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RQ_IDLE;
      rq_q   <= 1'b0;
      ack_q  <= 1'b0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
      dout_q <= '0;
      data_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        RQ_IDLE: if (ev_accept) begin
          dout_q <= {{PAD{1'b0}}, addr_i};
          oe_q   <= 1'b1;
          rq_q   <= 1'b1;
          st_q   <= RQ_REQ;
        end
        RQ_REQ: if (ev_req_acked) begin
          rq_q <= 1'b0;
          oe_q <= 1'b0;
          st_q <= RQ_WAIT_DATA;
        end
        RQ_WAIT_DATA: if (ev_data_seen) begin
          data_q <= bus_i;
          ack_q  <= 1'b1;
          st_q   <= RQ_ACK_DATA;
        end
        RQ_ACK_DATA: if (ev_rdy_gone) begin
          ack_q <= 1'b0;
          st_q  <= RQ_RELEASE;
        end
        RQ_RELEASE: if (ev_ack_clear) begin
          done_q <= 1'b1;
          st_q   <= RQ_IDLE;
        end
        default: st_q <= RQ_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != RQ_IDLE);
  assign done_o = done_q;
  assign data_o = data_q;
  assign rq_o   = rq_q;
  assign ack_o  = ack_q;
  assign oe_o   = oe_q;
  assign dout_o = dout_q;

  // R2: completion is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8: a pulse during a transaction does not replace the driven address
  p_addr_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && oe_q) |=> $stable(dout_q));
endmodule

// File: rtl/rdhs_responder.sv
module rdhs_responder
  import rdhs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_i,
  input  logic              rq_i,
  input  logic              ack_i,
  output logic              ack_o,
  output logic              rdy_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] dout_o
);
  rs_state_t         st_q;
  logic              ack_q, rdy_q, oe_q;
  logic [DATA_W-1:0] addr_q, dout_q, rd_word;
  logic              rq_s, ack_s;

  rdhs_sync #(.W(2), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({rq_i, ack_i}),
    .q_o  ({rq_s, ack_s})
  );

  rdhs_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .raddr_i(addr_q[ADDR_W-1:0]),
    .rdata_o(rd_word)
  );

  // named events for assertions
  logic ev_latch, ev_req_gone, ev_line_clear, ev_data_acked, ev_done;
  assign ev_latch      = (st_q == RS_IDLE)     && rq_s;
  assign ev_req_gone   = (st_q == RS_ACK_REQ)  && !rq_s;
  assign ev_line_clear = (st_q == RS_WAIT_CLR) && !ack_s;
  assign ev_data_acked = (st_q == RS_SEND)     && ack_s;
  assign ev_done       = (st_q == RS_FINISH)   && !ack_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RS_IDLE;
      ack_q  <= 1'b0;
      rdy_q  <= 1'b0;
      oe_q   <= 1'b0;
      addr_q <= '0;
      dout_q <= '0;
    end else begin
      unique case (st_q)
        RS_IDLE: if (ev_latch) begin
          addr_q <= bus_i;
          ack_q  <= 1'b1;
          st_q   <= RS_ACK_REQ;
        end
        RS_ACK_REQ: if (ev_req_gone) begin
          ack_q <= 1'b0;
          st_q  <= RS_WAIT_CLR;
        end
        RS_WAIT_CLR: if (ev_line_clear) begin
          dout_q <= rd_word;
          oe_q   <= 1'b1;
          rdy_q  <= 1'b1;
          st_q   <= RS_SEND;
        end
        RS_SEND: if (ev_data_acked) begin
          rdy_q <= 1'b0;
          oe_q  <= 1'b0;
          st_q  <= RS_FINISH;
        end
        RS_FINISH: if (ev_done) st_q <= RS_IDLE;
        default: st_q <= RS_IDLE;
      endcase
    end
  end

  assign ack_o  = ack_q;
  assign rdy_o  = rdy_q;
  assign oe_o   = oe_q;
  assign dout_o = dout_q;

  // R3: the captured address has nothing above the address field
  p_addr_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_latch |-> (bus_i >> ADDR_W) == '0);

  // R4: data-valid is only raised together with the responder driving
  p_rdy_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |-> oe_q);
endmodule

// File: rtl/rdhs_link.sv
module rdhs_link #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              rq_line_o,
  output logic              rdy_line_o,
  output logic              ack_line_o,
  output logic [DATA_W-1:0] bus_o,
  output logic              req_drive_o,
  output logic              rsp_drive_o
);
  logic              rq_w, rdy_w, ack_w, req_ack, rsp_ack, req_oe, rsp_oe;
  logic [DATA_W-1:0] bus_w, req_dout, rsp_dout;

  // shared lines: OR of the enabled drivers, no tri-states
  assign bus_w = (req_oe ? req_dout : '0) | (rsp_oe ? rsp_dout : '0);
  assign ack_w = req_ack | rsp_ack;

  rdhs_requester #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .addr_i (addr_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .data_o (data_o),
    .bus_i  (bus_w),
    .rdy_i  (rdy_w),
    .ack_i  (ack_w),
    .rq_o   (rq_w),
    .ack_o  (req_ack),
    .oe_o   (req_oe),
    .dout_o (req_dout)
  );

  rdhs_responder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rsp (
    .clk   (clk),
    .rst_n (rst_n),
    .bus_i (bus_w),
    .rq_i  (rq_w),
    .ack_i (ack_w),
    .ack_o (rsp_ack),
    .rdy_o (rdy_w),
    .oe_o  (rsp_oe),
    .dout_o(rsp_dout)
  );

  assign rq_line_o   = rq_w;
  assign rdy_line_o  = rdy_w;
  assign ack_line_o  = ack_w;
  assign bus_o       = bus_w;
  assign req_drive_o = req_oe;
  assign rsp_drive_o = rsp_oe;

  p_one_driver_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_oe && rsp_oe));

  p_req_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rq_w) |-> req_oe);

  p_req_fall_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rq_w) |-> ack_w);

  p_rdy_fall_acked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_w) |-> ack_w);

  p_ack_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_w) |-> ($past(rq_w, 2) || $past(rdy_w, 2)));

  p_no_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rq_w) |-> !$past(busy_o));

  p_quiet_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_oe && !rsp_oe) |-> (bus_w == '0));
endmodule

// File: tb/rdhs_link_tb_top.sv
module rdhs_link_tb_top;
  localparam int AW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          busy_o, done_o, rq_line_o, rdy_line_o, ack_line_o;
  logic          req_drive_o, rsp_drive_o;
  logic [DW-1:0] data_o, bus_o;

  always #10 clk = ~clk;  // 50 MHz

  rdhs_link #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .addr_i     (addr_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .data_o     (data_o),
    .rq_line_o  (rq_line_o),
    .rdy_line_o (rdy_line_o),
    .ack_line_o (ack_line_o),
    .bus_o      (bus_o),
    .req_drive_o(req_drive_o),
    .rsp_drive_o(rsp_drive_o)
  );

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // reference word, written as plain integer arithmetic
  function automatic int unsigned word_ref(input int unsigned a);
    return ((a * 12061) % 65536) ^ 23100;
  endfunction

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  // line monitor, sampled at the falling edge
  int unsigned exp_addr = 0;
  int overlap = 0;
  longint cyc = 0, rq_rise = 0, rdy_rise = 0;
  bit rq_p = 0, rdy_p = 0, ack_p = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (req_drive_o && rsp_drive_o) overlap++;
      if (rq_line_o && !rq_p) begin
        rq_rise = cyc;
        chk(bus_o == DW'(exp_addr), "R3 address on lines at request rise", bus_o, exp_addr);
      end
      if (rdy_line_o && !rdy_p) begin
        rdy_rise = cyc;
        chk(bus_o == DW'(word_ref(exp_addr)), "R4 word on lines at data-valid rise",
            bus_o, word_ref(exp_addr));
        chk(rsp_drive_o && !req_drive_o, "R4 only responder drives", {rsp_drive_o, req_drive_o}, 2);
      end
      if (rq_p && !rq_line_o) chk(ack_line_o, "R5 request fell with ack high", ack_line_o, 1);
      if (rdy_p && !rdy_line_o) chk(ack_line_o, "R7 data-valid fell with ack high", ack_line_o, 1);
      if (ack_line_o && !ack_p) begin
        if (rq_line_o)       chk(cyc - rq_rise >= 3, "R9 ack after request", cyc - rq_rise, 3);
        else if (rdy_line_o) chk(cyc - rdy_rise >= 3, "R9 ack after data-valid", cyc - rdy_rise, 3);
        else                 chk(1'b0, "R9 ack rose with no strobe", 0, 1);
      end
      if (!req_drive_o && !rsp_drive_o) begin
        if (bus_o != '0) chk(1'b0, "R10 undriven lines not zero", bus_o, 0);
      end
    end
    rq_p  = rq_line_o;
    rdy_p = rdy_line_o;
    ack_p = ack_line_o;
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      wrap_up();
    end
  end

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done_o) begin seen = 1; break; end
    end
  endtask

  task automatic pulse_start(input int unsigned a);
    start_i = 1'b1;
    addr_i  = AW'(a);
    @(negedge clk);
    start_i = 1'b0;
    addr_i  = '0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o, "R1 busy/done in reset", {busy_o, done_o}, 0);
    chk(!rq_line_o && !rdy_line_o && !ack_line_o, "R1 control wires in reset",
        {rq_line_o, rdy_line_o, ack_line_o}, 0);
    chk(!req_drive_o && !rsp_drive_o, "R1 drives in reset", {req_drive_o, rsp_drive_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !ack_line_o, "R1 first cycle after reset",
        {busy_o, done_o, ack_line_o}, 0);
    chk(bus_o == '0, "R10 idle lines zero", bus_o, 0);
  endtask

  task automatic t_read(input int unsigned a);
    bit seen;
    exp_addr = a;
    pulse_start(a);
    chk(busy_o, "R8 busy after start", busy_o, 1);
    wait_done(seen);
    chk(seen, "R2 done seen", seen, 1);
    chk(data_o == DW'(word_ref(a)), "R2 read word", data_o, word_ref(a));
    chk(!ack_line_o, "R8 ack low at done", ack_line_o, 0);
    @(negedge clk);
    chk(!done_o, "R2 done one cycle", done_o, 0);
    chk(data_o == DW'(word_ref(a)), "R2 word held", data_o, word_ref(a));
    chk(overlap == 0, "R6 drive overlap count", overlap, 0);
  endtask

  task automatic t_busy_start(input int unsigned a, input int unsigned b);
    bit seen;
    int rises;
    exp_addr = a;
    pulse_start(a);
    repeat (4) @(negedge clk);
    pulse_start(b);
    repeat (6) @(negedge clk);
    pulse_start(b);
    wait_done(seen);
    chk(seen, "R8 first read completes", seen, 1);
    chk(data_o == DW'(word_ref(a)), "R8 result unaffected by busy start", data_o, word_ref(a));
    rises = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (rq_line_o || busy_o) rises++;
    end
    chk(rises == 0, "R8 no second request", rises, 0);
    chk(data_o == DW'(word_ref(a)), "R8 word kept", data_o, word_ref(a));
  endtask

  task automatic t_back_to_back();
    bit seen;
    for (int k = 0; k < 4; k++) begin
      int unsigned a = (k * 5 + 3) % 16;
      exp_addr = a;
      pulse_start(a);
      wait_done(seen);
      chk(seen && data_o == DW'(word_ref(a)), "R2 back-to-back read", data_o, word_ref(a));
    end
    @(negedge clk);
    chk(overlap == 0, "R6 drive overlap after burst", overlap, 0);
  endtask

  initial begin
    t_reset();
    t_read(0);
    t_read(15);
    t_read(10);
    t_read(5);
    t_busy_start(7, 9);
    t_back_to_back();
    repeat (5) @(negedge clk);
    chk(bus_o == '0 && !ack_line_o, "R10 lines quiet at end", bus_o, 0);
    wrap_up();
  end
endmodule